// File: doc/BRIEF.md
# Dual-Mode Asynchronous FIFO with Status Flags

This block is a first-in first-out buffer with separate write and read clocks. At master reset it samples a mode input and keeps that choice until the next reset. In standard mode every word is handed out only on a read request. In fall-through mode the oldest word moves to the data output by itself. The read enable then consumes that word and brings up the next one.

Five flags report the fill level. The first shows empty or output-ready, and the second shows full or input-ready. The other three are half-full, programmable almost-empty and programmable almost-full. The almost-empty offset n and the almost-full offset m are inputs, captured during master reset. In fall-through mode the output register holds one word beyond the memory depth. For this reason the capacity and every threshold move up by one word in that mode. Pointers cross between the clocks as Gray code through two-stage synchronizers.

Top module: `dual_mode_async_fifo`

## Requirements
- R1: The mode is captured from `fwft_sel` while `mrs_n` is low (0 = standard, 1 = fall-through). It does not change until the next master reset.
- R2: In standard mode, `ef_or` is low while the FIFO is empty and high once a word is stored. `dout` changes only in the read clock edge after a read with `ren_n` low.
- R3: In fall-through mode, a word written into an empty FIFO appears on `dout` after the third rising read clock edge that follows the write edge. At that point `ef_or` goes low, with no read request needed.
- R4: Capacity is DEPTH words in standard mode and DEPTH+1 in fall-through mode. With no reads, `ff_ir` goes low after DEPTH writes in standard mode and goes high after DEPTH+1 writes in fall-through mode.
- R5: A write to a full FIFO is dropped. No stored word is lost or duplicated.
- R6: A read request on an empty FIFO has no effect. In standard mode `dout` keeps its value, and in fall-through mode `ef_or` stays high.
- R7: With k words stored, `pae_n` is high when k ≥ n+1 in standard mode or k ≥ n+2 in fall-through mode, and low otherwise.
- R8: `hf_n` is low when k ≥ DEPTH/2+1 in standard mode or k ≥ DEPTH/2+2 in fall-through mode, and high otherwise.
- R9: `paf_n` is low when k ≥ DEPTH−m in standard mode or k ≥ DEPTH+1−m in fall-through mode, and high otherwise.
- R10: The first read from a full FIFO clears the full indication. `ff_ir` goes high in standard mode and low in fall-through mode.
- R11: Words leave in the order they were written, with unrelated write and read clocks and concurrent traffic.
- R12: After master reset, `dout` is 0, `hf_n` and `paf_n` are high and `pae_n` is low. In standard mode `ef_or` is low and `ff_ir` is high; in fall-through mode `ef_or` is high and `ff_ir` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wen_n | input | 1 | Write enable, active low |
| din | input | DW | Write data |
| rclk | input | 1 | Read clock |
| ren_n | input | 1 | Read enable, active low |
| dout | output | DW | Read data |
| mrs_n | input | 1 | Master reset, active low, asynchronous |
| fwft_sel | input | 1 | Mode select, sampled during master reset |
| empty_off | input | AW | Almost-empty offset n, sampled during master reset |
| full_off | input | AW | Almost-full offset m, sampled during master reset |
| ef_or | output | 1 | Standard mode: empty flag, low when empty. Fall-through mode: output-ready, low when data is valid |
| ff_ir | output | 1 | Standard mode: full flag, low when full. Fall-through mode: input-ready, high when full |
| hf_n | output | 1 | Half-full, low when more than half full |
| pae_n | output | 1 | Almost-empty, low when at or below the offset |
| paf_n | output | 1 | Almost-full, low when within the offset of full |

## Verification
Both modes are filled one word at a time with no reads, drained one word at a time with no writes, and all five flags are compared at every count. This separates the per-mode thresholds, which differ by exactly one word. A single write into an empty fall-through FIFO is timed edge by edge, so a latency of two or four read edges cannot pass. Extra writes at full and read requests at empty are followed by a drain or refill that shows whether a word was dropped or duplicated. A final run with gapped concurrent traffic on a 10 ns write clock and a 14 ns read clock checks ordering across both the full and the empty boundaries.

// File: rtl/dual_mode_async_fifo.sv
module dual_mode_async_fifo #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          wen_n,
  input  logic [DW-1:0] din,
  input  logic          rclk,
  input  logic          ren_n,
  output logic [DW-1:0] dout,
  input  logic          mrs_n,
  input  logic          fwft_sel,
  input  logic [AW-1:0] empty_off,
  input  logic [AW-1:0] full_off,
  output logic          ef_or,
  output logic          ff_ir,
  output logic          hf_n,
  output logic          pae_n,
  output logic          paf_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2 + 1);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic          fwft;
  logic [AW-1:0] n_off, m_off;

  always_ff @(posedge wclk)
    if (!mrs_n) begin
      fwft  <= fwft_sel;
      n_off <= empty_off;
      m_off <= full_off;
    end

  // write side
  logic [PW-1:0] wbin, wgray, rg_w1, rg_w2, wcnt, wbin_nxt;
  logic          full, wr;

  assign wbin_nxt = wbin + PW'(1);
  assign wcnt     = wbin - g2b(rg_w2);
  assign full     = wcnt[AW];
  assign wr       = !wen_n && !full;

  always_ff @(posedge wclk or negedge mrs_n)
    if (!mrs_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_w1 <= '0;
      rg_w2 <= '0;
    end else begin
      rg_w1 <= rgray;
      rg_w2 <= rg_w1;
      if (wr) begin
        wbin  <= wbin_nxt;
        wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      end
    end

  always_ff @(posedge wclk)
    if (wr) mem[wbin[AW-1:0]] <= din;

  // read side
  logic [PW-1:0] rbin, rgray, wg_r1, wg_r2, rcnt, rbin_nxt;
  logic          empty, ov, pop;

  assign rbin_nxt = rbin + PW'(1);
  assign rcnt     = g2b(wg_r2) - rbin;
  assign empty    = (rcnt == '0);
  assign pop      = !empty && (fwft ? (!ov || !ren_n) : !ren_n);

  always_ff @(posedge rclk or negedge mrs_n)
    if (!mrs_n) begin
      rbin  <= '0;
      rgray <= '0;
      wg_r1 <= '0;
      wg_r2 <= '0;
      dout  <= '0;
      ov    <= 1'b0;
    end else begin
      wg_r1 <= wgray;
      wg_r2 <= wg_r1;
      if (pop) begin
        rbin  <= rbin_nxt;
        rgray <= rbin_nxt ^ (rbin_nxt >> 1);
        dout  <= mem[rbin[AW-1:0]];
      end
      if (fwft) ov <= pop || (ov && ren_n);
    end

  // flags: thresholds on memory count shift by one in fall-through mode via the output register
  assign ef_or = fwft ? !ov : !empty;
  assign ff_ir = fwft ? full : !full;
  assign hf_n  = !(wcnt >= HALF_P);
  assign paf_n = !(wcnt >= (DEPTH_P - {1'b0, m_off}));
  assign pae_n = (rcnt >= ({1'b0, n_off} + PW'(1)));

  AST_MODE_HELD: assert property (@(posedge wclk) disable iff (!mrs_n)
    1'b1 |=> $stable(fwft)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!mrs_n)
    wcnt <= DEPTH_P); // R5
  AST_RD_COUNT_BOUND: assert property (@(posedge rclk) disable iff (!mrs_n)
    rcnt <= DEPTH_P); // R11
  AST_FWFT_HEAD_LOADS: assert property (@(posedge rclk) disable iff (!mrs_n)
    fwft && !ov && !empty |=> ov); // R3
  AST_EMPTY_READ_STD: assert property (@(posedge rclk) disable iff (!mrs_n)
    !fwft && empty && !ren_n |=> $stable(dout)); // R6
  AST_EMPTY_READ_FWFT: assert property (@(posedge rclk) disable iff (!mrs_n)
    fwft && !ov && empty |=> !ov); // R6
endmodule

// File: tb/dual_mode_async_fifo_tb.sv
module dual_mode_async_fifo_tb;
  localparam int DW = 8, AW = 4, DEPTH = 16, NOFF = 3, MOFF = 2, NSTREAM = 48;

  logic wclk = 1'b1, rclk = 1'b0;
  logic wen_n = 1'b1, ren_n = 1'b1, mrs_n = 1'b0, fwft_sel = 1'b0;
  logic [DW-1:0] din = '0, dout;
  logic [AW-1:0] empty_off = AW'(NOFF), full_off = AW'(MOFF);
  logic ef_or, ff_ir, hf_n, pae_n, paf_n;

  int checks = 0, fails = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] seq = 8'h11;

  always #5 wclk = ~wclk;
  initial begin #3; forever begin rclk = ~rclk; #7; end end

  dual_mode_async_fifo #(.DW(DW), .AW(AW)) u_dut (
    .wclk(wclk), .wen_n(wen_n), .din(din), .rclk(rclk), .ren_n(ren_n), .dout(dout),
    .mrs_n(mrs_n), .fwft_sel(fwft_sel), .empty_off(empty_off), .full_off(full_off),
    .ef_or(ef_or), .ff_ir(ff_ir), .hf_n(hf_n), .pae_n(pae_n), .paf_n(paf_n));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
  endtask

  task automatic do_reset(input bit mode);
    mrs_n = 1'b0; fwft_sel = mode; wen_n = 1'b1; ren_n = 1'b1;
    repeat (4) @(posedge wclk);
    repeat (2) @(posedge rclk);
    #1 mrs_n = 1'b1;
    fwft_sel = ~mode; // R1: changing the select after reset must not matter
    q.delete();
    settle();
  endtask

  task automatic write_one(input bit accepted);
    @(negedge wclk);
    din = seq; wen_n = 1'b0;
    if (accepted) q.push_back(seq);
    seq = seq + 8'h13;
    @(negedge wclk);
    wen_n = 1'b1;
  endtask

  task automatic read_one(input bit mode);
    logic [DW-1:0] exp;
    exp = q.size() > 0 ? q.pop_front() : '0;
    @(negedge rclk);
    if (mode) check("R11 fall-through head", dout, exp);
    ren_n = 1'b0;
    @(negedge rclk);
    ren_n = 1'b1;
    if (!mode) check("R11 standard read data", dout, exp);
  endtask

  task automatic check_flags(input bit mode, input int k);
    if (!mode) begin
      check("R2 empty flag", ef_or, k > 0);
      check("R4 full flag", ff_ir, k < DEPTH);
    end else begin
      check("R3 output ready", ef_or, k == 0);
      check("R4 input ready", ff_ir, k >= DEPTH + 1);
    end
    check("R7 almost-empty", pae_n, k >= (mode ? NOFF + 2 : NOFF + 1));
    check("R8 half-full", hf_n, !(k >= (mode ? DEPTH/2 + 2 : DEPTH/2 + 1)));
    check("R9 almost-full", paf_n, !(k >= (mode ? DEPTH + 1 - MOFF : DEPTH - MOFF)));
  endtask

  task automatic stream(input bit mode);
    fork
      begin : writer
        int sent = 0, cyc = 0;
        while (sent < NSTREAM) begin
          @(posedge wclk); #1;
          cyc++;
          if (!(mode ? ff_ir : !ff_ir) && (cyc % 7) >= 2) begin
            din = seq; wen_n = 1'b0; q.push_back(seq); seq = seq + 8'h13; sent++;
          end else wen_n = 1'b1;
        end
        @(posedge wclk); #1 wen_n = 1'b1;
      end
      begin : reader
        int got = 0, issued = 0, cyc = 0;
        bit pending = 0;
        logic [DW-1:0] exp;
        while (got < NSTREAM) begin
          @(posedge rclk); #1;
          cyc++;
          if (!mode) begin
            if (pending) begin
              exp = q.pop_front();
              check("R11 stream order standard", dout, exp);
              got++;
            end
            pending = 0;
            if (ef_or && issued < NSTREAM && (cyc % 9) != 0) begin
              ren_n = 1'b0; pending = 1; issued++;
            end else ren_n = 1'b1;
          end else begin
            if (!ef_or && (cyc % 9) != 0) begin
              exp = q.pop_front();
              check("R11 stream order fall-through", dout, exp);
              got++; ren_n = 1'b0;
            end else ren_n = 1'b1;
          end
        end
        @(posedge rclk); #1 ren_n = 1'b1;
      end
    join
  endtask

  task automatic run_mode(input bit mode);
    int cap;
    logic [DW-1:0] last;
    cap = DEPTH + (mode ? 1 : 0);
    do_reset(mode);
    check("R12 reset dout", dout, 0);
    check("R12 reset ef_or", ef_or, mode ? 1 : 0);
    check("R12 reset ff_ir", ff_ir, mode ? 0 : 1);
    check("R12 reset hf_n", hf_n, 1);
    check("R12 reset pae_n", pae_n, 0);
    check("R12 reset paf_n", paf_n, 1);
    if (mode) begin
      @(negedge wclk); din = seq; wen_n = 1'b0; q.push_back(seq); seq = seq + 8'h13;
      @(negedge wclk); wen_n = 1'b1;
      @(posedge rclk); #1 check("R3 not ready after edge 1", ef_or, 1);
      @(posedge rclk); #1 check("R3 not ready after edge 2", ef_or, 1);
      @(posedge rclk); #1 check("R3 ready after edge 3", ef_or, 0);
      check("R3 data after edge 3", dout, q[0]);
      settle();
    end else begin
      write_one(1'b1);
      settle();
      check("R2 no data before read", dout, 0);
    end
    check("R1 mode held", ef_or, mode ? 0 : 1);
    check_flags(mode, 1);
    for (int k = 2; k <= cap; k++) begin
      write_one(1'b1);
      settle();
      check_flags(mode, k);
    end
    write_one(1'b0);
    settle();
    check_flags(mode, cap); // R5 dropped write
    for (int k = cap - 1; k >= 0; k--) begin
      read_one(mode);
      settle();
      if (k == cap - 1) check("R10 full released by first read", ff_ir, mode ? 0 : 1);
      check_flags(mode, k);
    end
    check("R5 no word lost or duplicated", q.size(), 0);
    last = dout;
    @(negedge rclk); ren_n = 1'b0;
    @(negedge rclk); ren_n = 1'b1;
    settle();
    check("R6 empty read flag", ef_or, mode ? 1 : 0);
    if (!mode) check("R6 empty read keeps dout", dout, last);
    write_one(1'b1);
    settle();
    read_one(mode);
    settle();
    check_flags(mode, 0);
    check("R6 no stray word", q.size(), 0);
    stream(mode);
    settle();
    check("R11 stream complete", q.size(), 0);
    check_flags(mode, 0);
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
    $finish;
  end

  initial begin
    run_mode(1'b0);
    run_mode(1'b1);
    summary();
    $finish;
  end
endmodule